// File: doc/BRIEF.md
# HDLC Transmit Frame Generator

This block turns a stream of host octets into a serial HDLC bit stream. The host offers one octet per beat on a valid/ready handshake and marks the final beat of each frame. The block brackets every frame with flag octets and appends a 16-bit frame check sequence, which it computes while the payload goes out. It inserts zero bits into the payload and check fields so that no run of ones there can imitate a flag.

The serial side advances by one bit for each clock cycle in which the bit-rate enable is high. When nothing is queued, the line carries an unbroken train of flags. A beat may be marked as carrying no octet. Such a marker ends the current frame after the octets already sent. When the marker is the very first beat of a frame, the frame has no payload, so it is dropped and the line keeps sending idle flags.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is asserted, and after it is released, `tx_bit` is 0 and `in_ready` is 1. The first eight bits sent after reset form a flag.
- R2: When no frame is pending, the output is a continuous train of flags. A flag is the pattern 0,1,1,1,1,1,1,0 in time order (octet 0x7E).
- R3: Every frame is preceded by a flag and closed by a flag. Flag bits are never subject to zero insertion.
- R4: Payload octets go out in the order they were accepted, each least significant bit first.
- R5: Right after the last payload octet comes a 16-bit check field, before the closing flag. The check is a CRC with polynomial x^16+x^12+x^5+1, processed least significant bit first (reflected constant 0x8408), and covers the payload bits only. The register is preset to 0xFFFF and the value is sent complemented, bit 0 first.
- R6: After five consecutive 1s in the payload or check field, a 0 is inserted. The count restarts at zero after every flag. A run of five that ends the check field still gets its 0 before the closing flag. The output never holds more than six 1s in a row.
- R7: A beat is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in four situations: while an inserted 0 is due, during the check field, during the closing flag, and at all times from the acceptance of a beat with `in_last`=1 until the closing flag has been sent.
- R8: A beat with `in_last`=1 and `in_empty`=1 carries no octet. It ends the frame after the octets already accepted, and `in_data` is ignored.
- R9: A frame whose first beat has `in_last`=1 and `in_empty`=1 produces no frame on the line, and the output stays in idle flags.
- R10: `tx_bit` changes only on a clock edge where `bit_en` is 1, and each such edge sends exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one output bit per high cycle |
| in_valid | input | 1 | Host beat valid |
| in_data | input | 8 | Payload octet |
| in_last | input | 1 | Beat is the final one of its frame |
| in_empty | input | 1 | Beat carries no octet (with in_last only) |
| in_ready | output | 1 | Block accepts a beat at the next rising edge |
| tx_bit | output | 1 | Serial HDLC output |

## Verification
Each output bit is registered on the rising edge where `bit_en` is high, so it is due one edge after that enable. The bench reads it at the following falling edge, and only for cycles in which the bench itself drove the enable. `in_ready` is a decode of registered state, so its value at a falling edge is the value the next rising edge will use. The bench drives beats and judges acceptance from that value. Frames are recovered by an independent deframer in the bench, and each recovered frame is compared against a queue of sent payloads and against CRC values from a bench function. Because the number of idle flags between frames is random, the comparison is made by frame order rather than by absolute cycle.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
   typedef enum logic [1:0] {
      ST_FLAG = 2'd0,
      ST_DATA = 2'd1,
      ST_FCS  = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       last;
      logic       empty;
   } beat_t;
endpackage

// File: rtl/hdlc_beat_buf.sv
module hdlc_beat_buf
   import hdlc_tx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  logic  pop,
   input  beat_t din,
   output beat_t dout,
   output logic  vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         dout <= '0;
      end else if (push) begin
         vld  <= 1'b1;
         dout <= din;
      end else if (pop) begin
         vld  <= 1'b0;
      end
   end

   AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !vld); // R7
   AST_BUF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> vld); // R4
endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
   parameter int RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic clr,
   input  logic bit_in,
   output logic stuff_req
);
   localparam int W = $clog2(RUN + 1);

   logic [W-1:0] ones;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ones <= '0;
      else if (clr)    ones <= '0;
      else if (adv)    ones <= bit_in ? ones + W'(1) : '0;
   end

   assign stuff_req = (ones == W'(RUN));

   AST_ONES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= W'(RUN)); // R6
   AST_NO_COUNT_WHILE_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_req |-> !adv); // R6
endmodule

// File: rtl/hdlc_crc_ser.sv
module hdlc_crc_ser #(
   parameter int           W      = 16,
   parameter logic [W-1:0] POLY   = 16'h8408,
   parameter logic [W-1:0] INIT   = 16'hFFFF,
   parameter bit           INVERT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         step,
   input  logic         din,
   output logic [W-1:0] fcs_nxt
);
   logic [W-1:0] crc, crc_nxt;

   always_comb crc_nxt = (crc >> 1) ^ ((crc[0] ^ din) ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= INIT;
      else if (init)  crc <= INIT;
      else if (step)  crc <= crc_nxt;
   end

   generate
      if (INVERT) begin : g_inv
         assign fcs_nxt = ~crc_nxt;
      end else begin : g_plain
         assign fcs_nxt = crc_nxt;
      end
   endgenerate

   AST_CRC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(init && step)); // R5
   AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (crc == INIT)); // R5
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int                FCS_W      = 16,
   parameter logic [FCS_W-1:0]  FCS_POLY   = 16'h8408,
   parameter logic [FCS_W-1:0]  FCS_INIT   = 16'hFFFF,
   parameter bit                FCS_INVERT = 1'b1,
   parameter int                STUFF_RUN  = 5,
   parameter logic [7:0]        FLAG_PAT   = 8'h7E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   input  logic       in_empty,
   output logic       in_ready,
   output logic       tx_bit
);
   localparam int OCT   = 8;
   localparam int CNT_W = $clog2(FCS_W);
   localparam int SH_W  = FCS_W;

   generate
      if (FCS_W < OCT) begin : g_bad_fcs
         $error("FCS_W must be at least one octet");
      end
      if (STUFF_RUN < 1 || STUFF_RUN > 5) begin : g_bad_run
         $error("STUFF_RUN must lie in 1..5 so a flag stays unique");
      end
   endgenerate

   tx_state_e        state;
   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cnt;
   logic             closing, cur_last, end_seen, tx_q;
   beat_t            beat_in, buf_q;
   logic             buf_vld, buf_push, buf_pop;
   logic             stuff_req, emit, cur_bit;
   logic             crc_init, crc_step, ones_adv, ones_clr;
   logic             oct_end, fcs_end, frame_close;
   logic [SH_W-1:0]  fcs_nxt;

   assign beat_in  = '{data: in_data, last: in_last, empty: in_empty};
   assign in_ready = !buf_vld && !end_seen && !closing && (state != ST_FCS) && !stuff_req;
   assign buf_push = in_valid && in_ready;

   assign emit        = bit_en && !stuff_req;
   assign oct_end     = (cnt == CNT_W'(OCT - 1));
   assign fcs_end     = (cnt == CNT_W'(FCS_W - 1));
   assign frame_close = cur_last || !buf_vld || buf_q.empty;
   assign cur_bit     = (state == ST_FLAG) ? FLAG_PAT[cnt[2:0]] : sh[0];

   assign buf_pop  = emit && oct_end && buf_vld &&
                     (state == ST_FLAG || (state == ST_DATA && !cur_last));
   assign crc_init = emit && oct_end && (state == ST_FLAG) && buf_vld && !buf_q.empty;
   assign crc_step = emit && (state == ST_DATA);
   assign ones_adv = emit && (state != ST_FLAG);
   assign ones_clr = (bit_en && stuff_req) || (emit && state == ST_FLAG);

   hdlc_beat_buf u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .push (buf_push),
      .pop  (buf_pop),
      .din  (beat_in),
      .dout (buf_q),
      .vld  (buf_vld)
   );

   hdlc_zero_stuffer #(.RUN(STUFF_RUN)) u_stuff (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (ones_adv),
      .clr      (ones_clr),
      .bit_in   (cur_bit),
      .stuff_req(stuff_req)
   );

   hdlc_crc_ser #(
      .W     (FCS_W),
      .POLY  (FCS_POLY),
      .INIT  (FCS_INIT),
      .INVERT(FCS_INVERT)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (crc_init),
      .step   (crc_step),
      .din    (cur_bit),
      .fcs_nxt(fcs_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_FLAG;
         sh       <= '0;
         cnt      <= '0;
         closing  <= 1'b0;
         cur_last <= 1'b0;
         end_seen <= 1'b0;
         tx_q     <= 1'b0;
      end else begin
         if (buf_push && in_last) end_seen <= 1'b1;
         if (bit_en) begin
            if (stuff_req) begin
               tx_q <= 1'b0;
            end else begin
               tx_q <= cur_bit;
               cnt  <= cnt + CNT_W'(1);
               unique case (state)
                  ST_FLAG: begin
                     if (oct_end) begin
                        cnt     <= '0;
                        closing <= 1'b0;
                        if (closing) end_seen <= 1'b0;
                        if (buf_vld) begin
                           if (buf_q.empty) begin
                              end_seen <= 1'b0;
                           end else begin
                              state    <= ST_DATA;
                              sh       <= SH_W'(buf_q.data);
                              cur_last <= buf_q.last;
                           end
                        end
                     end
                  end
                  ST_DATA: begin
                     sh <= sh >> 1;
                     if (oct_end) begin
                        cnt <= '0;
                        if (frame_close) begin
                           state <= ST_FCS;
                           sh    <= fcs_nxt;
                        end else begin
                           sh       <= SH_W'(buf_q.data);
                           cur_last <= buf_q.last;
                        end
                     end
                  end
                  ST_FCS: begin
                     sh <= sh >> 1;
                     if (fcs_end) begin
                        cnt     <= '0;
                        state   <= ST_FLAG;
                        closing <= 1'b1;
                     end
                  end
                  default: state <= ST_FLAG;
               endcase
            end
         end
      end
   end

   assign tx_bit = tx_q;

   AST_LAST_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_push && in_last) |=> !in_ready); // R7
   AST_STUFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && stuff_req) |=> !tx_bit); // R6
   AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit)); // R10
   AST_FCS_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FCS) |-> !buf_push); // R7
endmodule

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       in_valid;
   logic [7:0] in_data;
   logic       in_last;
   logic       in_empty;
   logic       in_ready;
   logic       tx_bit;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hdlc_tx_framer u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .in_valid(in_valid),
      .in_data (in_data),
      .in_last (in_last),
      .in_empty(in_empty),
      .in_ready(in_ready),
      .tx_bit  (tx_bit)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // expected frames
   logic [7:0] exp_data [0:2047];
   int         exp_off  [0:127];
   int         exp_len  [0:127];
   bit         exp_mark [0:127];
   int         fr_tx = 0, fr_rx = 0, wr_ptr = 0;
   logic [7:0] pay [0:31];

   // deframer state
   logic fb [0:1023];
   int   n = 0, run = 0, nrx = 0;
   bit   synced = 1'b0;
   logic [7:0] first8 = 8'h00;
   int   ones_err = 0, hold_err = 0, rdy_err = 0, unexp = 0, idle_flags = 0;
   int   last_acc_cnt = 0, last_acc_seen = 0;
   bit   win = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] fcs_of(input int off, input int k);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < k; i++)
         for (int b = 0; b < 8; b++) begin
            logic fbk = c[0] ^ exp_data[off+i][b];
            c = c >> 1;
            if (fbk) c = c ^ 16'h8408;
         end
      return ~c;
   endfunction

   task automatic eval_frame(input int len);
      int k;
      logic [15:0] got_fcs, want_fcs;
      bit pay_ok;
      if (len == 0) begin
         idle_flags++;
         return;
      end
      if (fr_rx >= fr_tx) begin
         unexp++;
         chk(1'b0, "R9", "unexpected frame on line", len, 0);
         return;
      end
      k = exp_len[fr_rx];
      chk(len == 8 * (k + 2), exp_mark[fr_rx] ? "R8" : "R3",
          "frame bit length between flags", len, 8 * (k + 2));
      if (len == 8 * (k + 2)) begin
         pay_ok = 1'b1;
         for (int j = 0; j < k; j++) begin
            logic [7:0] by;
            for (int b = 0; b < 8; b++) by[b] = fb[8*j+b];
            if (by != exp_data[exp_off[fr_rx]+j]) begin
               pay_ok = 1'b0;
               chk(1'b0, "R4", "payload octet", by, exp_data[exp_off[fr_rx]+j]);
            end
         end
         if (pay_ok) chk(1'b1, "R4", "payload", 0, 0);
         for (int b = 0; b < 16; b++) got_fcs[b] = fb[8*k+b];
         want_fcs = fcs_of(exp_off[fr_rx], k);
         chk(got_fcs == want_fcs, "R5", "check field", got_fcs, want_fcs);
      end
      chk(ones_err == 0, "R6", "run of ones beyond six", ones_err, 0);
      fr_rx++;
   endtask

   task automatic rx_bit(input logic b);
      if (nrx < 8) first8[nrx] = b;
      nrx++;
      if (b) begin
         run++;
         if (run > 6) ones_err++;
         if (synced && n < 1024) begin fb[n] = 1'b1; n++; end
      end else begin
         if (run == 6) begin
            if (synced) eval_frame(n - 7);
            synced = 1'b1;
            n = 0;
            win = 1'b0;
         end else if (run != 5) begin
            if (synced && n < 1024) begin fb[n] = 1'b0; n++; end
         end
         run = 0;
      end
   endtask

   always @(posedge clk)
      if (rst_n && in_valid && in_ready && in_last) last_acc_cnt <= last_acc_cnt + 1;

   // monitor and bit-rate enable
   initial begin
      bit   prev_en = 1'b0;
      logic last_tx = 1'b0;
      bit_en = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_en) rx_bit(tx_bit);
            else if (tx_bit !== last_tx) hold_err++;
            last_tx = tx_bit;
            if (last_acc_cnt != last_acc_seen) begin
               last_acc_seen = last_acc_cnt;
               win = 1'b1;
            end
            if (win && in_ready) rdy_err++;
            prev_en = ($urandom_range(0, 2) != 0);
            bit_en  = prev_en;
         end
      end
   end

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic put_beat(input logic [7:0] d, input logic last, input logic empty);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = last;
      in_empty = empty;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_empty = 1'b0;
   endtask

   task automatic send_frame(input int k, input bit marker_end);
      if (k > 0) begin
         exp_off[fr_tx]  = wr_ptr;
         exp_len[fr_tx]  = k;
         exp_mark[fr_tx] = marker_end;
         for (int i = 0; i < k; i++) exp_data[wr_ptr+i] = pay[i];
         wr_ptr += k;
         fr_tx++;
         for (int i = 0; i < k; i++)
            put_beat(pay[i], (i == k - 1) && !marker_end, 1'b0);
      end
      if (k == 0 || marker_end) put_beat(8'($urandom), 1'b1, 1'b1);
      repeat ($urandom_range(0, 20)) @(negedge clk);
   endtask

   initial begin
      int idle0;
      void'($urandom(32'd2718));
      rst_n = 1'b0;
      in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; in_empty = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_bit == 1'b0, "R1", "tx_bit in reset", tx_bit, 0);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      repeat (40) @(negedge clk);
      chk(nrx >= 8 && first8 == 8'h7E, "R1", "first octet after reset", first8, 8'h7E);
      chk(synced, "R2", "flag train after reset", synced, 1);

      // directed corner cases
      for (int i = 0; i < 6; i++) pay[i] = 8'hFF;
      send_frame(6, 1'b0);                                  // R6 heavy stuffing
      pay[0] = 8'h7E; pay[1] = 8'h7E; send_frame(2, 1'b0);   // R3 flag-like payload
      pay[0] = 8'h00; send_frame(1, 1'b0);                   // R4 single octet
      pay[0] = 8'h1F; pay[1] = 8'hF8; send_frame(2, 1'b0);   // R6 run across octets
      send_frame(0, 1'b0);                                   // R9 empty frame
      pay[0] = 8'hA5; pay[1] = 8'h3C; send_frame(2, 1'b1);   // R8 marker ends frame
      send_frame(0, 1'b0);                                   // R9 again, back to back
      pay[0] = 8'h01; send_frame(1, 1'b1);                   // R8 single octet + marker

      for (int f = 0; f < 30; f++) begin
         int k = $urandom_range(1, 12);
         for (int i = 0; i < k; i++)
            pay[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
         send_frame(k, $urandom_range(0, 3) == 0);
         if ($urandom_range(0, 7) == 0) send_frame(0, 1'b0);
      end

      for (int w = 0; w < 8000 && fr_rx < fr_tx; w++) @(negedge clk);
      chk(fr_rx == fr_tx, "R9", "frames received vs sent", fr_rx, fr_tx);
      chk(unexp == 0, "R9", "frames from empty requests", unexp, 0);
      idle0 = idle_flags;
      repeat (120) @(negedge clk);
      chk(idle_flags - idle0 >= 4, "R2", "idle flags while nothing queued",
          idle_flags - idle0, 4);
      chk(ones_err == 0, "R6", "run of ones beyond six", ones_err, 0);
      chk(hold_err == 0, "R10", "tx_bit moved without enable", hold_err, 0);
      chk(rdy_err == 0, "R7", "in_ready high after last beat", rdy_err, 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d frames", fr_rx, fr_tx);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule